// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block computes the architectural state change that a soft processor core makes when it takes a trap. There are four kinds of trap: a hardware exception, a memory-management exception, an external interrupt and a break. The core presents one request for one cycle. The request carries the trap cause, the current program counter, the pending branch target, the delay-slot, immediate-prefix and prefixed-branch flags, the machine status word and the exception status word.

One cycle later the block returns a single write bundle. The bundle holds:
- the link-register write (register index and value);
- the new machine status and exception status words;
- an optional branch-target register write;
- the cleared or passed-through instruction flags;
- the new program counter.

If the request describes an illegal entry, the block raises an error strobe and suppresses the whole bundle. The core applies the bundle to its register file and fetch unit. Both of those lie outside this block.

Each trap kind has its own vector and its own link register. A memory-management fault rewinds the saved address so that the faulting instruction, or the branch ahead of it, runs again. On every entry the translation-mode and user-mode bits are moved into their saved-copy positions.

Top module: `trap_entry_seq`

## Requirements
- R1: Cause encoding on `cause_i` is 0 hardware exception, 1 memory-management exception, 2 interrupt and 3 break. For causes 0 and 1 the new PC is 0x20, for cause 2 it is 0x10, and for cause 3 it is 0x18 when `hw_brk_i` is high. For cause 3 with `hw_brk_i` low, the new PC is `btarget_i`.
- R2: The link write depends on the cause:
  - cause 0 writes `pc_i`+4 to register 17;
  - cause 1 writes the PC to register 17, rewound as R3 describes;
  - cause 2 writes `pc_i` to register 14;
  - a hardware break writes `pc_i` to register 16;
  - a software break makes no link write (`link_we_o` low).
- R3: For cause 1 the link value is rewound from `pc_i` as follows:
  - by 8 when `dslot_i` and `bimm_i` are both high;
  - by 4 when `dslot_i` is high and `bimm_i` is low;
  - by 4 when only `imm_i` is high;
  - not at all when no flag is set.
- R4: For causes 0 and 1, bit 12 of the exception status output equals `dslot_i` and every other bit follows `esr_i`. In the same case, `btr_we_o` equals `dslot_i` and `btr_o` carries `btarget_i`. For causes 2 and 3 the status passes through unchanged and `btr_we_o` stays low.
- R5: On every entry, MSR bit 14 takes the old bit 13 and bit 12 takes the old bit 11. Bits 13 and 11 are then cleared. All other bits are kept unless R6 or R7 changes them.
- R6: Causes 0 and 1 set MSR bit 9 (exception in progress). Cause 3 sets MSR bit 3 (break in progress).
- R7: Cause 2 clears MSR bit 1 (interrupt enable).
- R8: Causes 0 and 1 return `dslot_o` and `imm_o` low. Causes 2 and 3 pass `dslot_i` and `imm_i` through.
- R9: Two conditions are illegal:
  - cause 0 while `exc_en_i` is low;
  - cause 2 while MSR bit 9 or bit 3 is set, bit 1 is clear, or `dslot_i` is high.

  An illegal request produces a one-cycle `err_o` with `wr_vld_o`, `link_we_o` and `btr_we_o` low.
- R10: Each request yields exactly one of `wr_vld_o` or `err_o`, high for one cycle, on the cycle after `req_i`. With no request both stay low. After reset every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Trap entry request, one cycle |
| cause_i | input | 2 | Trap cause code (R1) |
| hw_brk_i | input | 1 | Break is a hardware break |
| exc_en_i | input | 1 | Hardware exceptions are configured |
| pc_i | input | XW | Current program counter |
| btarget_i | input | XW | Pending branch target |
| dslot_i | input | 1 | Trapping instruction sits in a delay slot |
| imm_i | input | 1 | Immediate prefix pending |
| bimm_i | input | 1 | Delay-slot branch was immediate-prefixed |
| msr_i | input | XW | Current machine status word |
| esr_i | input | XW | Current exception status word |
| wr_vld_o | output | 1 | Write bundle valid |
| err_o | output | 1 | Illegal entry strobe |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | XW | Link register value |
| pc_o | output | XW | New program counter |
| msr_o | output | XW | New machine status word |
| esr_o | output | XW | New exception status word |
| btr_we_o | output | 1 | Branch-target register write enable |
| btr_o | output | XW | Branch-target register value |
| dslot_o | output | 1 | New delay-slot flag |
| imm_o | output | 1 | New immediate-prefix flag |

## Verification
The block keeps no state beyond its output register, so any internal error shows in the bundle of the same request, one cycle after `req_i`. A wrong cause decode shows as a wrong vector or link index. A wrong rewind shows as a link value that is off by 4 or 8. A misplaced mode shift shows as a wrong bit 11 to 14 in `msr_o`. A wrong guard term shows as an error strobe swapped with a valid strobe. The reference model therefore compares every strobe on every cycle and every data field whenever a bundle is expected. Directed cases cover each delay-slot and prefix combination and each error condition, and randomized requests cover the rest.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    CAUSE_HWX = 2'd0,
    CAUSE_MMU = 2'd1,
    CAUSE_IRQ = 2'd2,
    CAUSE_BRK = 2'd3
  } cause_e;

  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;
  localparam int ESR_DS  = 12;

  localparam int RIDX_W   = 5;
  localparam int LINK_IRQ = 14;
  localparam int LINK_BRK = 16;
  localparam int LINK_EXC = 17;
endpackage

// File: rtl/trap_guard.sv
module trap_guard
  import trap_pkg::*;
#(
  parameter int XW = 32
) (
  input  cause_e        cause_i,
  input  logic          exc_en_i,
  input  logic          dslot_i,
  input  logic [XW-1:0] msr_i,
  output logic          err_o
);
  logic irq_bad;

  always_comb begin
    irq_bad = msr_i[MSR_EIP] | msr_i[MSR_BIP] | ~msr_i[MSR_IE] | dslot_i;
    unique case (cause_i)
      CAUSE_HWX: err_o = ~exc_en_i;
      CAUSE_IRQ: err_o = irq_bad;
      default:   err_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trap_msr_xform.sv
module trap_msr_xform
  import trap_pkg::*;
#(
  parameter int XW = 32
) (
  input  cause_e        cause_i,
  input  logic [XW-1:0] msr_i,
  output logic [XW-1:0] msr_o
);
  logic [XW-1:0] keep;

  // mode bits move up one position into their saved copies
  for (genvar b = 0; b < XW; b++) begin : g_bit
    if (b == MSR_VMS) begin : g_vms
      assign keep[b] = msr_i[MSR_VM];
    end else if (b == MSR_UMS) begin : g_ums
      assign keep[b] = msr_i[MSR_UM];
    end else if (b == MSR_VM || b == MSR_UM) begin : g_clr
      assign keep[b] = 1'b0;
    end else begin : g_pass
      assign keep[b] = msr_i[b];
    end
  end

  always_comb begin
    msr_o = keep;
    unique case (cause_i)
      CAUSE_HWX, CAUSE_MMU: msr_o[MSR_EIP] = 1'b1;
      CAUSE_IRQ:            msr_o[MSR_IE]  = 1'b0;
      CAUSE_BRK:            msr_o[MSR_BIP] = 1'b1;
      default:              msr_o = keep;
    endcase
  end
endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_pkg::*;
#(
  parameter int          XW      = 32,
  parameter logic [31:0] VEC_EXC = 32'h20,
  parameter logic [31:0] VEC_IRQ = 32'h10,
  parameter logic [31:0] VEC_BRK = 32'h18
) (
  input  cause_e            cause_i,
  input  logic              hw_brk_i,
  input  logic [XW-1:0]     pc_i,
  input  logic [XW-1:0]     btarget_i,
  input  logic              dslot_i,
  input  logic              imm_i,
  input  logic              bimm_i,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XW-1:0]     link_val_o,
  output logic [XW-1:0]     pc_o
);
  localparam logic [XW-1:0] STEP = XW'(4);

  logic [XW-1:0] rewind;

  always_comb begin
    if (dslot_i)     rewind = bimm_i ? (STEP << 1) : STEP;
    else if (imm_i)  rewind = STEP;
    else             rewind = '0;
  end

  always_comb begin
    link_we_o  = 1'b1;
    link_idx_o = RIDX_W'(LINK_EXC);
    link_val_o = pc_i;
    pc_o       = XW'(VEC_EXC);
    unique case (cause_i)
      CAUSE_HWX: link_val_o = pc_i + STEP;
      CAUSE_MMU: link_val_o = pc_i - rewind;
      CAUSE_IRQ: begin
        link_idx_o = RIDX_W'(LINK_IRQ);
        pc_o       = XW'(VEC_IRQ);
      end
      CAUSE_BRK: begin
        link_idx_o = RIDX_W'(LINK_BRK);
        link_we_o  = hw_brk_i;
        pc_o       = hw_brk_i ? XW'(VEC_BRK) : btarget_i;
      end
      default: link_we_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int          XW      = 32,
  parameter logic [31:0] VEC_EXC = 32'h20,
  parameter logic [31:0] VEC_IRQ = 32'h10,
  parameter logic [31:0] VEC_BRK = 32'h18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    cause_i,
  input  logic          hw_brk_i,
  input  logic          exc_en_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] btarget_i,
  input  logic          dslot_i,
  input  logic          imm_i,
  input  logic          bimm_i,
  input  logic [XW-1:0] msr_i,
  input  logic [XW-1:0] esr_i,
  output logic          wr_vld_o,
  output logic          err_o,
  output logic          link_we_o,
  output logic [4:0]    link_idx_o,
  output logic [XW-1:0] link_val_o,
  output logic [XW-1:0] pc_o,
  output logic [XW-1:0] msr_o,
  output logic [XW-1:0] esr_o,
  output logic          btr_we_o,
  output logic [XW-1:0] btr_o,
  output logic          dslot_o,
  output logic          imm_o
);
  cause_e cause;
  logic   is_exc;
  logic   err_c, lwe_c, bwe_c;
  logic [RIDX_W-1:0] lidx_c;
  logic [XW-1:0]     lval_c, pc_c, msr_c, esr_c;

  assign cause  = cause_e'(cause_i);
  assign is_exc = (cause == CAUSE_HWX) || (cause == CAUSE_MMU);

  trap_guard #(.XW(XW)) u_guard (
    .cause_i  (cause),
    .exc_en_i (exc_en_i),
    .dslot_i  (dslot_i),
    .msr_i    (msr_i),
    .err_o    (err_c)
  );

  trap_msr_xform #(.XW(XW)) u_msr (
    .cause_i (cause),
    .msr_i   (msr_i),
    .msr_o   (msr_c)
  );

  trap_target_sel #(
    .XW(XW), .VEC_EXC(VEC_EXC), .VEC_IRQ(VEC_IRQ), .VEC_BRK(VEC_BRK)
  ) u_tgt (
    .cause_i    (cause),
    .hw_brk_i   (hw_brk_i),
    .pc_i       (pc_i),
    .btarget_i  (btarget_i),
    .dslot_i    (dslot_i),
    .imm_i      (imm_i),
    .bimm_i     (bimm_i),
    .link_we_o  (lwe_c),
    .link_idx_o (lidx_c),
    .link_val_o (lval_c),
    .pc_o       (pc_c)
  );

  always_comb begin
    esr_c = esr_i;
    if (is_exc) esr_c[ESR_DS] = dslot_i;
    bwe_c = is_exc & dslot_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_vld_o   <= 1'b0;
      err_o      <= 1'b0;
      link_we_o  <= 1'b0;
      btr_we_o   <= 1'b0;
      link_idx_o <= '0;
      link_val_o <= '0;
      pc_o       <= '0;
      msr_o      <= '0;
      esr_o      <= '0;
      btr_o      <= '0;
      dslot_o    <= 1'b0;
      imm_o      <= 1'b0;
    end else begin
      wr_vld_o  <= req_i & ~err_c;
      err_o     <= req_i & err_c;
      link_we_o <= req_i & ~err_c & lwe_c;
      btr_we_o  <= req_i & ~err_c & bwe_c;
      if (req_i) begin
        link_idx_o <= lidx_c;
        link_val_o <= lval_c;
        pc_o       <= pc_c;
        msr_o      <= msr_c;
        esr_o      <= esr_c;
        btr_o      <= btarget_i;
        dslot_o    <= dslot_i & ~is_exc;
        imm_o      <= imm_i & ~is_exc;
      end
    end
  end

  // R10
  vld_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_vld_o && err_o));

  // R10
  req_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (wr_vld_o || err_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!wr_vld_o && !err_o));

  // R5
  mode_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!wr_vld_o || (msr_o[MSR_VMS] == $past(msr_i[MSR_VM]) &&
                             msr_o[MSR_UMS] == $past(msr_i[MSR_UM]) &&
                             !msr_o[MSR_VM] && !msr_o[MSR_UM])));

  // R2
  link_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_we_o || btr_we_o) |-> wr_vld_o);

  // R1
  irq_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cause_i == CAUSE_IRQ) |=> (!wr_vld_o || pc_o == XW'(VEC_IRQ)));
endmodule

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
  localparam int XW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [1:0]    cause = '0;
  logic          hw_brk = 1'b0, exc_en = 1'b0;
  logic [XW-1:0] pc = '0, bt = '0, msr = '0, esr = '0;
  logic          ds = 1'b0, im = 1'b0, bi = 1'b0;

  logic          wr_vld, err, link_we, btr_we, ds_o, im_o;
  logic [4:0]    link_idx;
  logic [XW-1:0] link_val, pc_o, msr_o, esr_o, btr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected bundle for the response due at the next sampling point
  bit          e_vld, e_err, e_lwe, e_bwe, e_ds, e_im;
  int          e_lidx;
  logic [31:0] e_lval, e_pc, e_msr, e_esr, e_btr;

  trap_entry_seq #(.XW(XW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cause_i(cause),
    .hw_brk_i(hw_brk), .exc_en_i(exc_en), .pc_i(pc), .btarget_i(bt),
    .dslot_i(ds), .imm_i(im), .bimm_i(bi), .msr_i(msr), .esr_i(esr),
    .wr_vld_o(wr_vld), .err_o(err), .link_we_o(link_we),
    .link_idx_o(link_idx), .link_val_o(link_val), .pc_o(pc_o),
    .msr_o(msr_o), .esr_o(esr_o), .btr_we_o(btr_we), .btr_o(btr_o),
    .dslot_o(ds_o), .imm_o(im_o)
  );

  always #5 clk = ~clk;

  task automatic chk(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R10", "wr_vld", 32'(wr_vld), 32'(e_vld));
    chk("R9",  "err",    32'(err),    32'(e_err));
    chk("R2",  "link_we", 32'(link_we), 32'(e_lwe));
    chk("R4",  "btr_we", 32'(btr_we), 32'(e_bwe));
    if (e_vld) begin
      if (e_lwe) begin
        chk("R2", "link_idx", 32'(link_idx), 32'(e_lidx));
        chk("R3", "link_val", link_val, e_lval);
      end
      chk("R1", "pc", pc_o, e_pc);
      chk("R5", "msr", msr_o, e_msr);
      chk("R4", "esr", esr_o, e_esr);
      if (e_bwe) chk("R4", "btr", btr_o, e_btr);
      chk("R8", "dslot", 32'(ds_o), 32'(e_ds));
      chk("R8", "imm", 32'(im_o), 32'(e_im));
    end
  endtask

  task automatic model();
    bit exc, bad;
    exc = (cause == 2'd0) || (cause == 2'd1);
    bad = (cause == 2'd0 && !exc_en) ||
          (cause == 2'd2 && (msr[9] || msr[3] || !msr[1] || ds));
    e_vld = req && !bad;
    e_err = req && bad;
    e_lwe = e_vld && !(cause == 2'd3 && !hw_brk);
    e_bwe = e_vld && exc && ds;
    e_btr = bt;
    e_ds  = exc ? 1'b0 : ds;
    e_im  = exc ? 1'b0 : im;
    e_msr = msr;
    e_msr[14] = msr[13];
    e_msr[12] = msr[11];
    e_msr[13] = 1'b0;
    e_msr[11] = 1'b0;
    e_esr = esr;
    if (exc) e_esr[12] = ds;
    case (cause)
      2'd0: begin e_lidx = 17; e_lval = pc + 4; e_pc = 32'h20; e_msr[9] = 1'b1; end
      2'd1: begin
        e_lidx = 17; e_pc = 32'h20; e_msr[9] = 1'b1;
        if (ds)      e_lval = bi ? pc - 8 : pc - 4;
        else if (im) e_lval = pc - 4;
        else         e_lval = pc;
      end
      2'd2: begin e_lidx = 14; e_lval = pc; e_pc = 32'h10; e_msr[1] = 1'b0; end
      default: begin
        e_lidx = 16; e_lval = pc; e_msr[3] = 1'b1;
        e_pc = hw_brk ? 32'h18 : bt;
      end
    endcase
  endtask

  // one cycle: check the response due now, then drive the next request
  task automatic step(bit r, logic [1:0] c, bit hb, bit en, logic [31:0] p,
                      logic [31:0] b, bit d, bit i, bit bm, logic [31:0] m,
                      logic [31:0] s);
    @(negedge clk);
    compare();
    req = r; cause = c; hw_brk = hb; exc_en = en; pc = p; bt = b;
    ds = d; im = i; bbit(bm); msr = m; esr = s;
    model();
  endtask

  task automatic bbit(bit v);
    bi = v;
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 1'b0, 1'b1, '0, '0, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    e_vld = 0; e_err = 0; e_lwe = 0; e_bwe = 0; e_ds = 0; e_im = 0;
    e_lidx = 0; e_lval = 0; e_pc = 0; e_msr = 0; e_esr = 0; e_btr = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "reset wr_vld", 32'(wr_vld), 0);
    chk("R10", "reset err", 32'(err), 0);
    chk("R2", "reset link_we", 32'(link_we), 0);
    rst_n = 1'b1;
    idle();
    // R1 R2 R6 hardware exception, plain and in delay slot (R4)
    step(1, 0, 0, 1, 32'h1000, 32'h4000, 0, 0, 0, 32'h0000_2802, 32'h0000_0013);
    step(1, 0, 0, 1, 32'h1004, 32'h4440, 1, 0, 0, 32'h0000_0802, 32'h0000_1011);
    // R3 MMU rewind cases
    step(1, 1, 0, 1, 32'h2000, 32'h5000, 0, 0, 0, 32'h0000_2002, 32'h0);
    step(1, 1, 0, 1, 32'h2010, 32'h5010, 1, 0, 0, 32'h0000_2802, 32'h0);
    step(1, 1, 0, 1, 32'h2020, 32'h5020, 1, 0, 1, 32'h0000_0002, 32'h0);
    step(1, 1, 0, 1, 32'h2030, 32'h5030, 0, 1, 1, 32'h0000_0802, 32'h0);
    // R7 legal interrupt, then R9 illegal ones
    step(1, 2, 0, 1, 32'h3000, 32'h0, 0, 1, 0, 32'h0000_2802, 32'h55);
    step(1, 2, 0, 1, 32'h3004, 32'h0, 0, 0, 0, 32'h0000_0202, 32'h0);
    step(1, 2, 0, 1, 32'h3008, 32'h0, 0, 0, 0, 32'h0000_000a, 32'h0);
    step(1, 2, 0, 1, 32'h300c, 32'h0, 0, 0, 0, 32'h0000_0000, 32'h0);
    step(1, 2, 0, 1, 32'h3010, 32'h0, 1, 0, 0, 32'h0000_0002, 32'h0);
    step(1, 0, 0, 0, 32'h3014, 32'h0, 0, 0, 0, 32'h0000_0002, 32'h0);
    // R1 R6 hardware and software break
    step(1, 3, 1, 1, 32'h6000, 32'h7000, 0, 0, 0, 32'h0000_2800, 32'h9);
    step(1, 3, 0, 1, 32'h6004, 32'h7004, 0, 0, 0, 32'h0000_0800, 32'h9);
    idle();
    idle();
    for (int n = 0; n < 400; n++) begin
      step(1'($urandom_range(0, 3) != 0), 2'($urandom), 1'($urandom),
           1'($urandom_range(0, 3) != 0), $urandom & 32'hffff_fffc, $urandom,
           1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);
    end
    idle();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule